// File: doc/BRIEF.md
# Write-Through Invalidate Cache Controller

This block is the per-node controller of a small direct-mapped cache that writes through to memory over a shared, snooped bus. Each line holds one word, a tag and a single valid bit. The processor side offers one request at a time: address, write flag, write data and a one-cycle done pulse. The processor holds the request until it sees done, then drops it. Processor reads that hit are answered from the cache without using the bus. Read misses and all writes become atomic bus transactions. A read miss fills the line it maps to. A write updates the local copy only when that copy is already present.

The snoop port carries the transactions of the other masters on the bus. A snooped write whose address matches a valid line clears that line's valid bit. Snooped reads leave the cache unchanged, so any number of nodes may hold a block at the same time. A snoop always takes the tag array before the processor, so a pending processor request waits for that cycle.

Addresses are word addresses. The low `INDEX_W` bits select the line and the remaining upper bits form the tag.

Top module: `wti_cache_ctrl`

## Requirements
- R1: After reset, every line is invalid, `cpu_done` is 0 and `bus_req` is 0. The first read of any address therefore goes to the bus.
- R2: A processor read whose line is valid with a matching tag raises `cpu_done` one cycle after the request is accepted. It returns the stored word on `cpu_rdata` and never raises `bus_req`.
- R3: A processor read that misses raises `bus_req` with `bus_wr`=0 and the request address. `cpu_done` rises the cycle after `bus_ack`, with the word that came on `bus_rdata`. The line then holds that address, so the next read of it hits.
- R4: Every processor write raises `bus_req` with `bus_wr`=1, the request address and the write data. `cpu_done` rises the cycle after `bus_ack`.
- R5: When a write completes and its line is held with a matching tag, the stored word becomes the write data. A write that misses does not allocate: the line keeps its previous tag and contents.
- R6: A snooped write (`snp_valid`=1, `snp_wr`=1) whose address matches a valid line invalidates that line. The next processor read of that address goes to the bus.
- R7: A snooped read, or a snooped write whose tag differs from the stored tag, leaves the line valid with its data unchanged.
- R8: In any cycle where `snp_valid` is 1, the controller accepts no processor request. A request presented during N snoop cycles is accepted in the first cycle without a snoop, after any invalidation that those snoops cause.
- R9: While `bus_req` is 1 and `bus_ack` has not arrived, `bus_req`, `bus_wr`, `bus_addr` and `bus_wdata` stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_done` on a read |
| bus_req | output | 1 | Bus transaction pending |
| bus_wr | output | 1 | 1 = bus write, 0 = bus read |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_ack | input | 1 | One-cycle pulse: this node's transaction has completed |
| bus_rdata | input | DATA_W | Read data, valid with `bus_ack` |
| snp_valid | input | 1 | A transaction of another master is visible this cycle |
| snp_wr | input | 1 | The snooped transaction is a write |
| snp_addr | input | ADDR_W | Snooped word address |

## Verification
The assertions check, on every cycle, the cycle-level rules:
- a read hit never uses the bus and completes in one cycle;
- every write starts a bus write;
- the bus request holds steady until it is acknowledged;
- the processor stalls while a snoop is present;
- the valid bits obey the invalidate and fill commands.

Only the bench's sequences show the effects that need a history of operations:
- data written by a hit returned by a later read;
- a write miss leaving the resident line in place;
- a matching snooped write forcing a later read back to the bus;
- non-matching or read snoops leaving a hit intact;
- a conflicting tag replacing a line.

The bench compares each of these against its own model of tags and data, swept over every line index and several bus latencies.

// File: rtl/wti_pkg.sv
// Shared types for the write-through invalidate cache controller.
package wti_pkg;

    // Request sequencer states: idle/lookup, waiting on a bus read, waiting on a bus write
    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_BUS_RD = 2'd1,
        SQ_BUS_WR = 2'd2
    } seq_state_t;

endpackage

// File: rtl/wti_line_store.sv
// Tag, data and valid storage for a direct-mapped cache of one-word lines.
// It has two read ports: one for the processor lookup and one for the snoop lookup.
// It has three write commands:
// - fill: writes tag and data and sets the valid bit;
// - update: writes data only;
// - invalidate: clears the valid bit.
// Assumes that when an invalidate and a fill name the same line in one cycle,
// dropping the line is acceptable, so the invalidate wins.
module wti_line_store #(
    parameter int INDEX_W = 3,
    parameter int TAG_W   = 13,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] cpu_idx,
    output logic               cpu_valid,
    output logic [TAG_W-1:0]   cpu_tag,
    output logic [DATA_W-1:0]  cpu_data,
    input  logic [INDEX_W-1:0] snp_idx,
    output logic               snp_line_valid,
    output logic [TAG_W-1:0]   snp_line_tag,
    input  logic               fill_en,
    input  logic [INDEX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [DATA_W-1:0]  fill_data,
    input  logic               upd_en,
    input  logic [INDEX_W-1:0] upd_idx,
    input  logic [DATA_W-1:0]  upd_data,
    input  logic               inv_en,
    input  logic [INDEX_W-1:0] inv_idx
);
    localparam int LINES = 1 << INDEX_W;

    logic [LINES-1:0] valid_vec;
    logic [TAG_W-1:0]  tag_arr  [LINES];
    logic [DATA_W-1:0] data_arr [LINES];

    for (genvar i = 0; i < LINES; i++) begin : g_line
        localparam logic [INDEX_W-1:0] MY_IDX = INDEX_W'(i);
        logic              v_q;
        logic [TAG_W-1:0]  t_q;
        logic [DATA_W-1:0] d_q;

        // Valid bit: reset clears it, an invalidate clears it, a fill sets it
        always_ff @(posedge clk) begin
            if (!rst_n)
                v_q <= 1'b0;
            else if (inv_en && inv_idx == MY_IDX)
                v_q <= 1'b0;
            else if (fill_en && fill_idx == MY_IDX)
                v_q <= 1'b1;
        end

        // Tag and data: a fill loads both, an update loads data only
        always_ff @(posedge clk) begin
            if (fill_en && fill_idx == MY_IDX) begin
                t_q <= fill_tag;
                d_q <= fill_data;
            end else if (upd_en && upd_idx == MY_IDX) begin
                d_q <= upd_data;
            end
        end

        assign valid_vec[i] = v_q;
        assign tag_arr[i]   = t_q;
        assign data_arr[i]  = d_q;
    end

    // Read port muxes for the processor lookup and the snoop lookup
    always_comb begin
        cpu_valid      = valid_vec[cpu_idx];
        cpu_tag        = tag_arr[cpu_idx];
        cpu_data       = data_arr[cpu_idx];
        snp_line_valid = valid_vec[snp_idx];
        snp_line_tag   = tag_arr[snp_idx];
    end

    AST_INV_CLEARS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_en |=> !valid_vec[$past(inv_idx)]); // R6

    AST_FILL_SETS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_en && !(inv_en && inv_idx == fill_idx)) |=> valid_vec[$past(fill_idx)]); // R3

endmodule

// File: rtl/wti_snoop_unit.sv
// Snoop lookup. Every snooped transaction is checked against the line its address maps to.
// A snooped write that hits a valid line with the same tag produces an invalidate command.
// Snooped reads never disturb the line.
// While any snoop is present, the unit raises a busy flag that stalls the processor lookup.
// Assumes the snoop inputs carry only transactions of other masters.
module wti_snoop_unit #(
    parameter int ADDR_W  = 16,
    parameter int INDEX_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      snp_valid,
    input  logic                      snp_wr,
    input  logic [ADDR_W-1:0]         snp_addr,
    output logic [INDEX_W-1:0]        look_idx,
    input  logic                      line_valid,
    input  logic [ADDR_W-INDEX_W-1:0] line_tag,
    output logic                      inv_en,
    output logic [INDEX_W-1:0]        inv_idx,
    output logic                      snoop_busy
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [TAG_W-1:0] snp_tag;
    logic             tag_match;

    // Split the snooped address and compare it against the resident line
    always_comb begin
        look_idx  = snp_addr[INDEX_W-1:0];
        snp_tag   = snp_addr[ADDR_W-1:INDEX_W];
        tag_match = line_valid && (line_tag == snp_tag);
    end

    // Invalidate only on a foreign write to a held block; any snoop blocks the processor
    always_comb begin
        inv_en     = snp_valid && snp_wr && tag_match;
        inv_idx    = look_idx;
        snoop_busy = snp_valid;
    end

    AST_SNOOP_READ_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && !snp_wr) |-> !inv_en); // R7

endmodule

// File: rtl/wti_req_seq.sv
// Processor request sequencer.
// In the idle state, it looks up the processor address and accepts the request
// unless a snoop holds the array.
// - A read hit completes on the next cycle.
// - A read miss issues a bus read and fills the line when the bus acknowledges.
// - A write always issues a bus write. At the acknowledge, the write updates the line
//   only if the line still holds that address, so invalidations ordered on the bus
//   before it are respected.
// Assumes one outstanding request, held by the processor until done.
module wti_req_seq
    import wti_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cpu_req,
    input  logic                      cpu_wr,
    input  logic [ADDR_W-1:0]         cpu_addr,
    input  logic [DATA_W-1:0]         cpu_wdata,
    output logic                      cpu_done,
    output logic [DATA_W-1:0]         cpu_rdata,
    input  logic                      snoop_busy,
    output logic [INDEX_W-1:0]        look_idx,
    input  logic                      line_valid,
    input  logic [ADDR_W-INDEX_W-1:0] line_tag,
    input  logic [DATA_W-1:0]         line_data,
    output logic                      bus_req,
    output logic                      bus_wr,
    output logic [ADDR_W-1:0]         bus_addr,
    output logic [DATA_W-1:0]         bus_wdata,
    input  logic                      bus_ack,
    input  logic [DATA_W-1:0]         bus_rdata,
    output logic                      fill_en,
    output logic [INDEX_W-1:0]        fill_idx,
    output logic [ADDR_W-INDEX_W-1:0] fill_tag,
    output logic [DATA_W-1:0]         fill_data,
    output logic                      upd_en,
    output logic [INDEX_W-1:0]        upd_idx,
    output logic [DATA_W-1:0]         upd_data
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    seq_state_t        state_q;
    logic              done_q;
    logic [DATA_W-1:0] rdata_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic [ADDR_W-1:0] look_addr;
    logic [TAG_W-1:0]  look_tag;
    logic              hit;
    logic              accept;

    // Lookup address: the live request while idle, the latched one during a bus transaction
    always_comb begin
        look_addr = (state_q == SQ_IDLE) ? cpu_addr : req_addr_q;
        look_idx  = look_addr[INDEX_W-1:0];
        look_tag  = look_addr[ADDR_W-1:INDEX_W];
        hit       = line_valid && (line_tag == look_tag);
        accept    = (state_q == SQ_IDLE) && cpu_req && !done_q && !snoop_busy;
    end

    // Control: state sequencing and the done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (accept) begin
                        if (cpu_wr)   state_q <= SQ_BUS_WR;
                        else if (hit) done_q  <= 1'b1;
                        else          state_q <= SQ_BUS_RD;
                    end
                end
                SQ_BUS_RD, SQ_BUS_WR: begin
                    if (bus_ack) begin
                        done_q  <= 1'b1;
                        state_q <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Datapath: latch the accepted request and capture the read result
    always_ff @(posedge clk) begin
        if (accept) begin
            req_addr_q  <= cpu_addr;
            req_wdata_q <= cpu_wdata;
            if (!cpu_wr && hit)
                rdata_q <= line_data;
        end else if (state_q == SQ_BUS_RD && bus_ack) begin
            rdata_q <= bus_rdata;
        end
    end

    // Bus request fields come straight from the latched request
    always_comb begin
        bus_req   = (state_q != SQ_IDLE);
        bus_wr    = (state_q == SQ_BUS_WR);
        bus_addr  = req_addr_q;
        bus_wdata = req_wdata_q;
        cpu_done  = done_q;
        cpu_rdata = rdata_q;
    end

    // Array commands: fill on a read-miss acknowledge, update on a write hit at acknowledge
    always_comb begin
        fill_en   = (state_q == SQ_BUS_RD) && bus_ack;
        fill_idx  = look_idx;
        fill_tag  = look_tag;
        fill_data = bus_rdata;
        upd_en    = (state_q == SQ_BUS_WR) && bus_ack && hit;
        upd_idx   = look_idx;
        upd_data  = req_wdata_q;
    end

    AST_HIT_STAYS_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !cpu_wr && hit) |=> (cpu_done && !bus_req)); // R2

    AST_WRITE_GOES_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cpu_wr) |=> (bus_req && bus_wr && !cpu_done)); // R4

    AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_wr) && $stable(bus_addr)
                                   && $stable(bus_wdata))); // R9

    AST_SNOOP_STALLS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_IDLE && snoop_busy) |=> !cpu_done); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done); // R3

    AST_MISS_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack) |=> (cpu_done && !bus_req)); // R4

endmodule

// File: rtl/wti_cache_ctrl.sv
// Top of the write-through invalidate cache controller.
// It connects the line store, the snoop lookup and the processor request sequencer.
// Assumes an atomic bus:
// - this node's transaction and a snooped transaction never complete in the same cycle;
// - bus_ack comes only while bus_req is high.
module wti_cache_ctrl #(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    parameter int INDEX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic              bus_wr,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              snp_valid,
    input  logic              snp_wr,
    input  logic [ADDR_W-1:0] snp_addr
);
    localparam int TAG_W = ADDR_W - INDEX_W;

    logic [INDEX_W-1:0] cpu_idx, snp_idx;
    logic               cpu_valid, snp_line_valid;
    logic [TAG_W-1:0]   cpu_tag, snp_line_tag;
    logic [DATA_W-1:0]  cpu_data;
    logic               fill_en, upd_en, inv_en, snoop_busy;
    logic [INDEX_W-1:0] fill_idx, upd_idx, inv_idx;
    logic [TAG_W-1:0]   fill_tag;
    logic [DATA_W-1:0]  fill_data, upd_data;

    wti_line_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) store_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_idx(cpu_idx), .cpu_valid(cpu_valid), .cpu_tag(cpu_tag), .cpu_data(cpu_data),
        .snp_idx(snp_idx), .snp_line_valid(snp_line_valid), .snp_line_tag(snp_line_tag),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data),
        .inv_en(inv_en), .inv_idx(inv_idx)
    );

    wti_snoop_unit #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) snoop_i (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_wr(snp_wr), .snp_addr(snp_addr),
        .look_idx(snp_idx), .line_valid(snp_line_valid), .line_tag(snp_line_tag),
        .inv_en(inv_en), .inv_idx(inv_idx), .snoop_busy(snoop_busy)
    );

    wti_req_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)) seq_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .snoop_busy(snoop_busy),
        .look_idx(cpu_idx), .line_valid(cpu_valid), .line_tag(cpu_tag), .line_data(cpu_data),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_tag(fill_tag), .fill_data(fill_data),
        .upd_en(upd_en), .upd_idx(upd_idx), .upd_data(upd_data)
    );

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk)
        !rst_n |=> (!cpu_done && !bus_req)); // R1

    AST_ACK_ONLY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> bus_req); // R9

endmodule

// File: tb/wti_cache_ctrl_tb_top.sv
// Self-checking bench: sweeps every line index through a fixed sequence of hits,
// misses, writes, snoops and stalls. Expected values come from a bench model of
// the tags, valid bits and stored words.
module wti_cache_ctrl_tb_top;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int INDEX_W = 3;
    localparam int LINES   = 1 << INDEX_W;
    localparam int TAG_W   = ADDR_W - INDEX_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cpu_req = 1'b0, cpu_wr = 1'b0;
    logic [ADDR_W-1:0] cpu_addr = '0;
    logic [DATA_W-1:0] cpu_wdata = '0;
    logic              cpu_done;
    logic [DATA_W-1:0] cpu_rdata;
    logic              bus_req, bus_wr;
    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_wdata;
    logic              bus_ack = 1'b0;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic              snp_valid = 1'b0, snp_wr = 1'b0;
    logic [ADDR_W-1:0] snp_addr = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic              m_valid [LINES];
    logic [TAG_W-1:0]  m_tag   [LINES];
    logic [DATA_W-1:0] m_data  [LINES];

    always #4 clk = ~clk;

    wti_cache_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INDEX_W(INDEX_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_done(cpu_done), .cpu_rdata(cpu_rdata),
        .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .snp_valid(snp_valid), .snp_wr(snp_wr), .snp_addr(snp_addr)
    );

    function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
        return {a, ~a} ^ 32'hA5C3_1E07;
    endfunction

    function automatic logic [ADDR_W-1:0] mk_addr(input int tag, input int idx);
        return {TAG_W'(tag), INDEX_W'(idx)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_snoop(input logic wr, input logic [ADDR_W-1:0] a);
        int i = int'(a[INDEX_W-1:0]);
        if (wr && m_valid[i] && m_tag[i] == a[ADDR_W-1:INDEX_W])
            m_valid[i] = 1'b0;
    endtask

    // One snooped transaction of another master, one cycle long
    task automatic snoop(input logic wr, input logic [ADDR_W-1:0] a);
        @(negedge clk);
        snp_valid = 1'b1; snp_wr = wr; snp_addr = a;
        @(negedge clk);
        snp_valid = 1'b0;
        model_snoop(wr, a);
    endtask

    // Processor operation with an optional snoop held for `stall` cycles alongside it
    task automatic cpu_op(input logic wr, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                          input int lat, input int stall, input logic s_wr,
                          input logic [ADDR_W-1:0] s_addr, input string tag);
        int i = int'(a[INDEX_W-1:0]);
        logic [TAG_W-1:0] t = a[ADDR_W-1:INDEX_W];
        bit hit, saw, done;
        int cyc, w;
        logic [DATA_W-1:0] exp_rd;
        if (stall > 0) model_snoop(s_wr, s_addr);
        hit = m_valid[i] && m_tag[i] == t;
        exp_rd = hit ? m_data[i] : mem_word(a);
        @(negedge clk);
        cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
        if (stall > 0) begin snp_valid = 1'b1; snp_wr = s_wr; snp_addr = s_addr; end
        cyc = 0; w = 0; saw = 1'b0; done = 1'b0;
        while (!done && cyc < 60) begin
            @(negedge clk);
            cyc++;
            bus_ack = 1'b0;
            if (cyc == stall) snp_valid = 1'b0;
            if (cpu_done) begin
                done = 1'b1;
            end else if (bus_req) begin
                if (!saw) begin
                    chk(bus_addr == a, wr ? "R4" : "R3", {tag, " bus addr"}, 32'(bus_addr), 32'(a));
                    chk(bus_wr == wr, wr ? "R4" : "R3", {tag, " bus dir"}, 32'(bus_wr), 32'(wr));
                    if (wr) chk(bus_wdata == wd, "R4", {tag, " bus data"}, bus_wdata, wd);
                end else begin
                    chk(bus_addr == a && bus_wr == wr, "R9", {tag, " held"}, 32'(bus_addr), 32'(a));
                end
                saw = 1'b1;
                if (w == lat) begin bus_ack = 1'b1; bus_rdata = mem_word(bus_addr); end
                w++;
            end
        end
        cpu_req = 1'b0; bus_ack = 1'b0; snp_valid = 1'b0;
        chk(done, "R4", {tag, " completion"}, 32'(done), 32'd1);
        if (wr) begin
            chk(saw, "R4", {tag, " write on bus"}, 32'(saw), 32'd1);
            chk(cyc == stall + lat + 2, "R4", {tag, " write cycles"}, 32'(cyc), 32'(stall + lat + 2));
            if (hit) m_data[i] = wd;
        end else if (hit) begin
            chk(!saw, "R2", {tag, " hit used bus"}, 32'(saw), 32'd0);
            chk(cyc == stall + 1, stall > 0 ? "R8" : "R2", {tag, " hit cycles"}, 32'(cyc), 32'(stall + 1));
            chk(cpu_rdata == exp_rd, "R2", {tag, " hit data"}, cpu_rdata, exp_rd);
        end else begin
            chk(saw, "R3", {tag, " miss on bus"}, 32'(saw), 32'd1);
            chk(cyc == stall + lat + 2, "R3", {tag, " miss cycles"}, 32'(cyc), 32'(stall + lat + 2));
            chk(cpu_rdata == exp_rd, "R3", {tag, " miss data"}, cpu_rdata, exp_rd);
            m_valid[i] = 1'b1; m_tag[i] = t; m_data[i] = exp_rd;
        end
    endtask

    // Watchdog: an expired run counts as a failed check and still prints the summary
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < LINES; i++) begin m_valid[i] = 1'b0; m_tag[i] = '0; m_data[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(!cpu_done, "R1", "done after reset", 32'(cpu_done), 32'd0);
        chk(!bus_req, "R1", "bus_req after reset", 32'(bus_req), 32'd0);
        for (int idx = 0; idx < LINES; idx++) begin
            logic [ADDR_W-1:0] a = mk_addr(idx + 1, idx);
            logic [ADDR_W-1:0] b = mk_addr(idx + 17, idx);
            logic [ADDR_W-1:0] o = mk_addr(idx + 1, (idx + 1) % LINES);
            int lat = idx % 3;
            cpu_op(1'b0, a, '0, lat, 0, 1'b0, '0, "R1 first read miss");
            cpu_op(1'b0, a, '0, lat, 0, 1'b0, '0, "R2 read hit");
            cpu_op(1'b1, a, 32'hC0DE_0000 + 32'(idx), lat, 0, 1'b0, '0, "R5 write hit");
            cpu_op(1'b0, a, '0, lat, 0, 1'b0, '0, "R5 read after write hit");
            snoop(1'b1, b);
            cpu_op(1'b0, a, '0, lat, 0, 1'b0, '0, "R7 other-tag snoop write");
            snoop(1'b0, a);
            cpu_op(1'b0, a, '0, lat, 0, 1'b0, '0, "R7 snoop read");
            snoop(1'b1, a);
            cpu_op(1'b0, a, '0, lat, 0, 1'b0, '0, "R6 read after invalidate");
            cpu_op(1'b1, b, 32'hBEEF_0000 + 32'(idx), lat, 0, 1'b0, '0, "R5 write miss");
            cpu_op(1'b0, a, '0, lat, 0, 1'b0, '0, "R5 line kept after write miss");
            cpu_op(1'b0, b, '0, lat, 0, 1'b0, '0, "R3 conflict replace");
            cpu_op(1'b0, a, '0, lat, 0, 1'b0, '0, "R3 evicted tag misses");
            cpu_op(1'b0, a, '0, lat, 2, 1'b0, o, "R8 stall by snoop read");
            cpu_op(1'b0, a, '0, lat, 1, 1'b1, a, "R8 R6 stall by matching snoop write");
            cpu_op(1'b1, a, 32'h1234_0000 + 32'(idx), lat, 3, 1'b1, o, "R8 write stalled");
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule